// File: doc/BRIEF.md
# Smart Card Serial Status Flags

This block holds two status flags for a half-duplex smart card serial channel: a parity-error flag and a transmit-end flag. It does not shift characters or generate baud timing. It watches pulses from the receiver and transmitter, a half-etu tick from the baud generator, and status register accesses from the bus. From these it keeps the flags current.

When a received character fails parity, the parity-error flag latches. The character still lands in the receive data register, but the receive-full indication is held back. Further reception stays blocked until software clears the flag. In clocked synchronous mode, transmission is blocked as well.

The transmit-end flag rises a fixed number of half-etu ticks after each transmission start. That number depends on the guard and block mode bits. Software clears the flag through the usual read-1-then-write-0 pattern on the transmit-empty bit, or a DMA write of the transmit data register clears it.

Top module: `sc_status_flags`

## Requirements
- R1: A one-cycle `parity_err_pulse` sets `perr` at the next clock edge. `rdrf_suppress` is high in the cycle of the pulse and in every cycle while `perr` is 1.
- R2: `rx_block` equals `perr`. `tx_block` is 1 exactly when `perr` is 1 and `sync_mode` is 1.
- R3: `perr` clears at a clock edge where `stat_wr` is 1 with `wr_perr` = 0, but only if the parity-error arm bit is set. Without the arm bit, such a write leaves `perr` unchanged.
- R4: The value of `rx_en`, including a change from 1 to 0, never alters `perr`.
- R5: After a `tx_start` pulse, the block counts `half_etu_tick` pulses. The interval is reached on tick 25 when `guard_mode`=0 and `block_mode`=0, on tick 23 when `guard_mode`=0 and `block_mode`=1, and on tick 22 when `guard_mode`=1, whatever `block_mode` is. A new `tx_start` restarts the count from zero, and it wins over a tick in the same cycle. Once the interval is reached, the count stops until the next start.
- R6: When the interval is reached, `tend` sets at the next edge only if `err_sig` is 0 and `tdre` is 1 in that cycle. Otherwise `tend` keeps its value.
- R7: In every cycle where `tx_en` is 0 and `err_sig` is 0, `tend` is 1 after the next edge.
- R8: `tend` clears when `dma_tdr_wr` is 1. It also clears when `stat_wr` is 1 with `wr_tdre` = 0 while the transmit-empty arm bit is set.
- R9: While `rst_n` is low, `perr` is 0 and `tend` is 1 after each clock edge, and both arm bits are cleared.
- R10: If a set condition for a flag and a clear condition for the same flag occur in the same cycle, the flag ends at 1.
- R11: An arm bit sets on a cycle with `stat_rd` = 1 when its flag reads 1 (`perr`, or the `tdre` input). Any cycle with `stat_wr` = 1 clears it, and the write takes precedence over a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| wr_perr | input | 1 | Value written to the parity-error bit |
| wr_tdre | input | 1 | Value written to the transmit-empty bit |
| guard_mode | input | 1 | Guard-time mode select |
| block_mode | input | 1 | Block transfer mode select |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| err_sig | input | 1 | Error signal status from the card side |
| tdre | input | 1 | Transmit data register empty flag |
| sync_mode | input | 1 | Clocked synchronous mode select |
| parity_err_pulse | input | 1 | One-cycle parity failure on a received character |
| tx_start | input | 1 | One-cycle start of transmission |
| dma_tdr_wr | input | 1 | DMA write of the transmit data register |
| half_etu_tick | input | 1 | One pulse per half elementary time unit |
| perr | output | 1 | Parity-error flag |
| tend | output | 1 | Transmit-end flag |
| rdrf_suppress | output | 1 | Hold off the receive-full flag |
| rx_block | output | 1 | Reception blocked |
| tx_block | output | 1 | Transmission blocked |

## Verification
A wrong tick count or a wrong mode decode moves the rise of `tend` off its expected cycle, and it shows at the port one clock after the interval. A stale or wrongly set arm bit stays hidden until the next status write. That write then clears a flag it should leave alone, or fails to clear one, and the difference appears one cycle later. Because `perr` drives all three blocking outputs combinationally, a corrupted `perr` shows on them in the same cycle.

// File: rtl/scsf_pkg.sv
// Package: shared types and helpers for the smart card status flag unit.
// Assumes the mode bits are stable for the duration of a transmission.
package scsf_pkg;

    typedef enum logic [1:0] {
        SCSF_MODE_STD   = 2'd0,
        SCSF_MODE_BLOCK = 2'd1,
        SCSF_MODE_GUARD = 2'd2
    } scsf_mode_e;

    // Map the guard and block bits to a transmit timing mode.
    function automatic scsf_mode_e scsf_decode_mode(input logic guard_bit, input logic block_bit);
        if (guard_bit)
            return SCSF_MODE_GUARD;
        else if (block_bit)
            return SCSF_MODE_BLOCK;
        else
            return SCSF_MODE_STD;
    endfunction

endpackage

// File: rtl/scsf_arm_bit.sv
// Module: records that software has read a flag as 1.
// Assumes rd and wr are single-cycle bus strobes; a write disarms first.
module scsf_arm_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic wr,
    input  logic flag_val,
    output logic armed
);

    // Arm on a read that sees 1, disarm on any write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (wr)
            armed <= 1'b0;
        else if (rd && flag_val)
            armed <= 1'b1;
    end

    assert_disarm_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !armed);
    assert_arm_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && flag_val && !wr) |=> armed);

endmodule

// File: rtl/scsf_perr_flag.sv
// Module: parity-error flag with read-1-then-write-0 clearing.
// Assumes parity_pulse lasts one cycle per bad character; set beats clear.
module scsf_perr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic parity_pulse,
    input  logic sw_clear,
    output logic flag
);

    // Hold the parity-error state; hardware set takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (parity_pulse)
            flag <= 1'b1;
        else if (sw_clear)
            flag <= 1'b0;
    end

    assert_set_on_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        parity_pulse |=> flag);
    assert_only_clear_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !sw_clear) |=> flag);

endmodule

// File: rtl/scsf_tend_timer.sv
// Module: counts half-etu ticks from a transmission start up to a mode target.
// Assumes one tick per half etu; start restarts the count and wins over a tick.
module scsf_tend_timer
    import scsf_pkg::*;
#(
    parameter int TICKS_STD   = 25,
    parameter int TICKS_BLOCK = 23,
    parameter int TICKS_GUARD = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic guard_bit,
    input  logic block_bit,
    output logic interval_hit
);

    localparam int MAX_A   = (TICKS_STD > TICKS_BLOCK) ? TICKS_STD : TICKS_BLOCK;
    localparam int MAX_T   = (MAX_A > TICKS_GUARD) ? MAX_A : TICKS_GUARD;
    localparam int CNT_W   = $clog2(MAX_T + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] target;
    logic             running;
    scsf_mode_e       mode;

    // Select the target count for the current mode.
    always_comb begin
        mode = scsf_decode_mode(guard_bit, block_bit);
        case (mode)
            SCSF_MODE_GUARD: target = CNT_W'(TICKS_GUARD);
            SCSF_MODE_BLOCK: target = CNT_W'(TICKS_BLOCK);
            default:         target = CNT_W'(TICKS_STD);
        endcase
    end

    assign cnt_inc      = cnt + CNT_W'(1);
    assign interval_hit = running && tick && !start && (cnt_inc == target);

    // Advance the tick count while a transmission interval is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            running <= 1'b1;
        end else if (running && tick) begin
            if (cnt_inc == target) begin
                cnt     <= '0;
                running <= 1'b0;
            end else begin
                cnt <= cnt_inc;
            end
        end
    end

    assert_hit_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        interval_hit |=> !running);
    assert_start_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && cnt == '0));

endmodule

// File: rtl/scsf_tend_flag.sv
// Module: transmit-end flag register with set, hold and clear sources.
// Assumes all inputs are synchronous; set sources beat clear sources.
module scsf_tend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic interval_hit,
    input  logic tx_en,
    input  logic err_sig,
    input  logic tdre,
    input  logic sw_clear,
    input  logic dma_clear,
    output logic flag
);

    logic set_now;

    assign set_now = (!tx_en && !err_sig) || (interval_hit && !err_sig && tdre);

    // Update the transmit-end state with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b1;
        else if (set_now)
            flag <= 1'b1;
        else if (sw_clear || dma_clear)
            flag <= 1'b0;
    end

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !err_sig) |=> flag);
    assert_rise_needs_no_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(!err_sig));
    assert_fall_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(sw_clear || dma_clear));

endmodule

// File: rtl/sc_status_flags.sv
// Module: top of the smart card status flag unit. Combines the parity-error
// flag, the transmit-end timer and flag, and the read-armed clear logic.
// Assumes all strobes and pulses are single-cycle and synchronous to clk.
module sc_status_flags #(
    parameter int TICKS_STD   = 25,
    parameter int TICKS_BLOCK = 23,
    parameter int TICKS_GUARD = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic wr_perr,
    input  logic wr_tdre,
    input  logic guard_mode,
    input  logic block_mode,
    input  logic rx_en,
    input  logic tx_en,
    input  logic err_sig,
    input  logic tdre,
    input  logic sync_mode,
    input  logic parity_err_pulse,
    input  logic tx_start,
    input  logic dma_tdr_wr,
    input  logic half_etu_tick,
    output logic perr,
    output logic tend,
    output logic rdrf_suppress,
    output logic rx_block,
    output logic tx_block
);

    logic perr_armed;
    logic tdre_armed;
    logic perr_sw_clear;
    logic tdre_sw_clear;
    logic interval_hit;

    scsf_arm_bit u_perr_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (stat_rd),
        .wr       (stat_wr),
        .flag_val (perr),
        .armed    (perr_armed)
    );

    scsf_arm_bit u_tdre_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (stat_rd),
        .wr       (stat_wr),
        .flag_val (tdre),
        .armed    (tdre_armed)
    );

    assign perr_sw_clear = stat_wr && !wr_perr && perr_armed;
    assign tdre_sw_clear = stat_wr && !wr_tdre && tdre_armed;

    scsf_perr_flag u_perr (
        .clk          (clk),
        .rst_n        (rst_n),
        .parity_pulse (parity_err_pulse),
        .sw_clear     (perr_sw_clear),
        .flag         (perr)
    );

    scsf_tend_timer #(
        .TICKS_STD   (TICKS_STD),
        .TICKS_BLOCK (TICKS_BLOCK),
        .TICKS_GUARD (TICKS_GUARD)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (tx_start),
        .tick         (half_etu_tick),
        .guard_bit    (guard_mode),
        .block_bit    (block_mode),
        .interval_hit (interval_hit)
    );

    scsf_tend_flag u_tend (
        .clk          (clk),
        .rst_n        (rst_n),
        .interval_hit (interval_hit),
        .tx_en        (tx_en),
        .err_sig      (err_sig),
        .tdre         (tdre),
        .sw_clear     (tdre_sw_clear),
        .dma_clear    (dma_tdr_wr),
        .flag         (tend)
    );

    // Derive the blocking and receive-full hold-off outputs from the flag.
    always_comb begin
        rdrf_suppress = parity_err_pulse || perr;
        rx_block      = perr;
        tx_block      = perr && sync_mode;
    end

    assert_rx_enable_no_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !parity_err_pulse && !stat_wr) |=> $stable(perr));
    assert_clear_needs_write0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr) |-> $past(stat_wr && !wr_perr));
    assert_dma_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_tdr_wr && tx_en && !interval_hit) |=> !tend);

endmodule

// File: tb/sc_status_flags_tb.sv
module sc_status_flags_tb;

    logic clk = 1'b0;
    logic rst_n;
    logic stat_rd, stat_wr, wr_perr, wr_tdre;
    logic guard_mode, block_mode, rx_en, tx_en, err_sig, tdre, sync_mode;
    logic parity_err_pulse, tx_start, dma_tdr_wr, half_etu_tick;
    logic perr, tend, rdrf_suppress, rx_block, tx_block;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state
    bit m_perr, m_tend, m_arm_p, m_arm_t, m_run;
    int m_cnt;

    always #4 clk = ~clk;

    sc_status_flags u_dut (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .wr_perr(wr_perr), .wr_tdre(wr_tdre), .guard_mode(guard_mode),
        .block_mode(block_mode), .rx_en(rx_en), .tx_en(tx_en), .err_sig(err_sig),
        .tdre(tdre), .sync_mode(sync_mode), .parity_err_pulse(parity_err_pulse),
        .tx_start(tx_start), .dma_tdr_wr(dma_tdr_wr), .half_etu_tick(half_etu_tick),
        .perr(perr), .tend(tend), .rdrf_suppress(rdrf_suppress),
        .rx_block(rx_block), .tx_block(tx_block)
    );

    task automatic chk(input string req, input logic act, input bit exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    function automatic int target_ticks();
        if (guard_mode) return 22;
        if (block_mode) return 23;
        return 25;
    endfunction

    // Compare all outputs with the reference, then clock once and advance it.
    task automatic cyc();
        bit hit, nperr, ntend;
        #1;
        if (!rst_n) begin
            chk("R9 perr", perr, m_perr);
            chk("R9 tend", tend, m_tend);
        end else begin
            chk("R1 R3 R4 R10 R11 perr", perr, m_perr);
            chk("R5 R6 R7 R8 R10 R11 tend", tend, m_tend);
            chk("R1 rdrf_suppress", rdrf_suppress, parity_err_pulse | m_perr);
            chk("R2 rx_block", rx_block, m_perr);
            chk("R2 tx_block", tx_block, m_perr & sync_mode);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_perr = 0; m_tend = 1; m_arm_p = 0; m_arm_t = 0; m_run = 0; m_cnt = 0;
        end else begin
            hit = m_run && half_etu_tick && !tx_start && (m_cnt + 1 == target_ticks());
            nperr = m_perr;
            if (parity_err_pulse) nperr = 1;
            else if (stat_wr && !wr_perr && m_arm_p) nperr = 0;
            ntend = m_tend;
            if ((!tx_en && !err_sig) || (hit && !err_sig && tdre)) ntend = 1;
            else if (dma_tdr_wr || (stat_wr && !wr_tdre && m_arm_t)) ntend = 0;
            if (stat_wr) begin m_arm_p = 0; m_arm_t = 0; end
            else if (stat_rd) begin
                if (m_perr) m_arm_p = 1;
                if (tdre) m_arm_t = 1;
            end
            if (tx_start) begin m_run = 1; m_cnt = 0; end
            else if (m_run && half_etu_tick) begin
                if (m_cnt + 1 == target_ticks()) begin m_run = 0; m_cnt = 0; end
                else m_cnt++;
            end
            m_perr = nperr; m_tend = ntend;
        end
        @(negedge clk);
        stat_rd = 0; stat_wr = 0; parity_err_pulse = 0; tx_start = 0;
        dma_tdr_wr = 0; half_etu_tick = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic bus_read();
        stat_rd = 1; cyc();
    endtask

    task automatic bus_write(input bit vp, input bit vt);
        stat_wr = 1; wr_perr = vp; wr_tdre = vt; cyc();
    endtask

    // Start a transmission and deliver half-etu ticks every other cycle.
    task automatic run_tx(input int ticks);
        tx_start = 1; cyc();
        for (int i = 0; i < ticks; i++) begin
            half_etu_tick = 1; cyc();
            cyc();
        end
    endtask

    initial begin
        rst_n = 0; stat_rd = 0; stat_wr = 0; wr_perr = 1; wr_tdre = 1;
        guard_mode = 0; block_mode = 0; rx_en = 1; tx_en = 0; err_sig = 0;
        tdre = 1; sync_mode = 0; parity_err_pulse = 0; tx_start = 0;
        dma_tdr_wr = 0; half_etu_tick = 0;
        m_perr = 0; m_tend = 1; m_arm_p = 0; m_arm_t = 0; m_run = 0; m_cnt = 0;
        @(negedge clk);
        idle(3);                                  // R9 reset values
        rst_n = 1;
        idle(2);

        // R1 R2: parity error sets flag and blocks
        sync_mode = 1;
        parity_err_pulse = 1; cyc();
        idle(2);
        // R4: dropping receive enable keeps the flag
        rx_en = 0; idle(3); rx_en = 1; idle(1);
        // R3: write 0 without a prior read is ignored
        bus_write(0, 1); idle(1);
        // R11 R3: read arms, write 0 clears
        bus_read(); bus_write(0, 1); idle(2);
        // R10: set and clear in the same cycle
        parity_err_pulse = 1; cyc();
        bus_read(); stat_wr = 1; wr_perr = 0; parity_err_pulse = 1; cyc();
        idle(1);
        // R11: read then write 1 disarms, later write 0 does nothing
        bus_read(); bus_write(1, 1); bus_write(0, 1); idle(1);
        bus_read(); bus_write(0, 1); sync_mode = 0; idle(2);

        // R7: hold while transmitter disabled
        tx_en = 0; dma_tdr_wr = 1; cyc(); idle(1);
        tx_en = 1; idle(1);
        // R8: software clear of tend
        bus_read(); bus_write(1, 0); idle(1);
        // R5 R6: each mode
        for (int md = 0; md < 3; md++) begin
            guard_mode = (md == 2); block_mode = (md == 1);
            run_tx(26); idle(2);
            dma_tdr_wr = 1; cyc(); idle(1);     // R8 DMA clear
        end
        guard_mode = 1; block_mode = 1; run_tx(23);
        dma_tdr_wr = 1; cyc();
        // R6: error signal or non-empty data blocks the set
        guard_mode = 0; block_mode = 0;
        err_sig = 1; run_tx(26); err_sig = 0; idle(1);
        tdre = 0; run_tx(26); tdre = 1; idle(1);
        // R5: restart midway
        run_tx(10); run_tx(26); idle(2);

        // Mixed random traffic
        for (int i = 0; i < 6000; i++) begin
            if (i % 400 == 0) begin
                guard_mode = $urandom_range(0, 1); block_mode = $urandom_range(0, 1);
            end
            rx_en = ($urandom_range(0, 9) != 0);
            tx_en = ($urandom_range(0, 19) != 0);
            err_sig = ($urandom_range(0, 9) == 0);
            tdre = ($urandom_range(0, 3) != 0);
            sync_mode = $urandom_range(0, 1);
            stat_rd = ($urandom_range(0, 15) == 0);
            stat_wr = ($urandom_range(0, 19) == 0);
            wr_perr = $urandom_range(0, 1); wr_tdre = $urandom_range(0, 1);
            parity_err_pulse = ($urandom_range(0, 59) == 0);
            tx_start = ($urandom_range(0, 79) == 0);
            dma_tdr_wr = ($urandom_range(0, 49) == 0);
            half_etu_tick = (i % 2 == 0);
            cyc();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule